// File: doc/BRIEF.md
# Speculative Load Address Table

This block is a small fully associative table that supports data speculation in a processor core. When an early (advanced) load issues, the core allocates an entry that records the target register and the byte range the load reads. Every store probes the table with its own byte range. Any entry whose bytes overlap the stored bytes is dropped, because its speculative data may be stale.

Before the core uses speculatively loaded data, it issues a check for the target register. The table answers hit (the data is still good) or miss (reload or branch to recovery). The check can either consume the entry or leave it in place. The core can also drop a single register's entry, or empty the whole table.

The table has a fixed capacity. When it is full, a new allocation silently evicts an older entry in round-robin order, so a later check on the evicted register misses. One command and one store probe are accepted per cycle. When both arrive together, the store takes effect first. A check result appears on the cycle after the check.

Top module: `spec_addr_table`

## Requirements
- R1: After reset the table is empty: every check misses, and `res_valid` is low until a check is issued.
- R2: An allocate command (`cmd_op` = 1) records the tag {`cmd_fp`, `cmd_reg`} together with the range of 2^`cmd_size` bytes starting at `cmd_addr`. A later check (`cmd_op` = 2) with the same tag hits. A general register and a floating-point register with the same index are distinct tags.
- R3: A check with `cmd_clear` = 0 that hits leaves the entry in place, so a repeated check hits again.
- R4: A check with `cmd_clear` = 1 that hits reports hit and removes the entry, so the next check on that tag misses. A check on a tag that is not present reports miss.
- R5: A store probe (`st_valid`) covers 2^`st_size` bytes from `st_addr`. It removes every entry whose byte range shares at least one byte with it. Entries that merely touch the store's range, without sharing a byte, stay.
- R6: When a store probe and a check arrive in the same cycle, the check sees the table after the store has been applied.
- R7: Allocating a tag that is already present overwrites that entry's range; the table never holds two entries for one tag.
- R8: The table holds ENTRIES (32) entries. An allocation fills the lowest-numbered free slot. When no slot is free, it evicts the slot under a round-robin pointer; the pointer starts at slot 0 and advances by one on each eviction.
- R9: An invalidate-register command (`cmd_op` = 3) removes only the entry with the given tag, and has no effect when no entry matches.
- R10: An invalidate-all command (`cmd_op` = 4) empties the table.
- R11: `res_valid` is high exactly on the cycle after a check command, with `res_hit` giving the outcome. `res_valid` is low after any other command or after no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 0 idle, 1 allocate, 2 check, 3 invalidate register, 4 invalidate all |
| cmd_clear | input | 1 | For a check: remove the entry on hit |
| cmd_reg | input | REG_IDX_W | Register index of the command |
| cmd_fp | input | 1 | Register class: 1 floating-point, 0 general |
| cmd_addr | input | ADDR_W | Start byte address for allocate |
| cmd_size | input | SIZE_W | Log2 of the allocate access size in bytes |
| st_valid | input | 1 | A store probe is present this cycle |
| st_addr | input | ADDR_W | Start byte address of the store |
| st_size | input | SIZE_W | Log2 of the store size in bytes |
| res_valid | output | 1 | Check result present (cycle after a check) |
| res_hit | output | 1 | Check outcome: 1 hit, 0 miss |

## Verification
The store tests use ranges that abut an entry by exactly one byte on either side, together with ranges that share a single byte with it. An overlap compare that was off by one would either remove a neighbour or keep a stale entry. A same-cycle store and check on the same entry must miss; a design that ordered the check first would wrongly report hit. The capacity test fills every slot and then allocates twice more, checking that the first and second tags are evicted in turn. A wrong pointer start, or a pointer that does not advance, would evict the wrong register. Re-allocation and the class bit are also exercised: a design that added a second entry, or ignored the register class, would show hits after the entry should have gone.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;
   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_ALLOC   = 3'd1,
      OP_CHECK   = 3'd2,
      OP_INV_REG = 3'd3,
      OP_INV_ALL = 3'd4
   } sat_op_e;
endpackage

// File: rtl/sat_range_cmp.sv
`timescale 1ns/1ps
// Byte-range overlap between two naturally sized accesses (2**size bytes)
module sat_range_cmp #(
   parameter int ADDR_W = 48,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [SIZE_W-1:0] a_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [SIZE_W-1:0] b_size,
   output logic              overlap
);
   localparam int EW = ADDR_W + 1;   // one spare bit so the end never wraps

   logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

   always_comb begin
      a_lo = {1'b0, a_addr};
      b_lo = {1'b0, b_addr};
      a_hi = a_lo + (EW'(1) << a_size) - EW'(1);
      b_hi = b_lo + (EW'(1) << b_size) - EW'(1);
      overlap = (a_lo <= b_hi) && (b_lo <= a_hi);
   end
endmodule

// File: rtl/sat_first_set.sv
`timescale 1ns/1ps
// Lowest-index set bit finder
module sat_first_set #(
   parameter int N  = 32,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/sat_rr_ptr.sv
`timescale 1ns/1ps
// Round-robin victim pointer, wraps at N-1
module sat_rr_ptr #(
   parameter int N  = 32,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   output logic [IW-1:0] ptr
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + IW'(1);
   end
endmodule

// File: rtl/spec_addr_table.sv
`timescale 1ns/1ps
module spec_addr_table
   import sat_pkg::*;
#(
   parameter int ENTRIES   = 32,
   parameter int REG_IDX_W = 7,
   parameter int ADDR_W    = 48,
   parameter int SIZE_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic                 cmd_clear,
   input  logic [REG_IDX_W-1:0] cmd_reg,
   input  logic                 cmd_fp,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [SIZE_W-1:0]    cmd_size,
   input  logic                 st_valid,
   input  logic [ADDR_W-1:0]    st_addr,
   input  logic [SIZE_W-1:0]    st_size,
   output logic                 res_valid,
   output logic                 res_hit
);
   localparam int TAG_W = REG_IDX_W + 1;
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int MAX_BYTES_LOG = (1 << SIZE_W) - 1;

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("spec_addr_table: ENTRIES must be at least 2");
   end
   if (REG_IDX_W < 1) begin : g_bad_reg
      $error("spec_addr_table: REG_IDX_W must be at least 1");
   end
   if (SIZE_W < 1 || ADDR_W <= MAX_BYTES_LOG) begin : g_bad_size
      $error("spec_addr_table: address too narrow for the largest access");
   end

   // entry storage
   logic [ENTRIES-1:0] ent_vld;
   logic [TAG_W-1:0]   ent_tag  [ENTRIES];
   logic [ADDR_W-1:0]  ent_addr [ENTRIES];
   logic [SIZE_W-1:0]  ent_size [ENTRIES];

   // command decode
   logic is_alloc, is_check, is_inv_reg, is_inv_all;
   logic [TAG_W-1:0] tag_in;

   assign is_alloc   = cmd_valid && (cmd_op == OP_ALLOC);
   assign is_check   = cmd_valid && (cmd_op == OP_CHECK);
   assign is_inv_reg = cmd_valid && (cmd_op == OP_INV_REG);
   assign is_inv_all = cmd_valid && (cmd_op == OP_INV_ALL);
   assign tag_in     = {cmd_fp, cmd_reg};

   // per-entry store overlap and tag compare
   logic [ENTRIES-1:0] st_ovl, st_kill, tag_eq, live, live_hit;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      sat_range_cmp #(
         .ADDR_W (ADDR_W),
         .SIZE_W (SIZE_W)
      ) u_cmp (
         .a_addr  (ent_addr[i]),
         .a_size  (ent_size[i]),
         .b_addr  (st_addr),
         .b_size  (st_size),
         .overlap (st_ovl[i])
      );
      assign st_kill[i] = st_valid && ent_vld[i] && st_ovl[i];
      assign tag_eq[i]  = ent_vld[i] && (ent_tag[i] == tag_in);
   end

   // the store is applied first: everything below sees the post-store table
   assign live     = ent_vld & ~st_kill;
   assign live_hit = tag_eq  & ~st_kill;

   // slot selection for allocation
   logic             hit_found, free_found;
   logic [IDX_W-1:0] hit_idx, free_idx, rr_idx, wr_idx;
   logic             rr_adv;

   sat_first_set #(.N(ENTRIES), .IW(IDX_W)) u_hit_sel (
      .vec   (live_hit),
      .found (hit_found),
      .idx   (hit_idx)
   );

   sat_first_set #(.N(ENTRIES), .IW(IDX_W)) u_free_sel (
      .vec   (~live),
      .found (free_found),
      .idx   (free_idx)
   );

   assign rr_adv = is_alloc && !hit_found && !free_found;

   sat_rr_ptr #(.N(ENTRIES), .IW(IDX_W)) u_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (rr_adv),
      .ptr     (rr_idx)
   );

   always_comb begin
      if (hit_found)       wr_idx = hit_idx;
      else if (free_found) wr_idx = free_idx;
      else                 wr_idx = rr_idx;
   end

   logic [ENTRIES-1:0] wr_sel, vld_nxt;

   assign wr_sel = is_alloc ? (ENTRIES'(1) << wr_idx) : '0;

   always_comb begin
      vld_nxt = live;
      if (is_alloc)                    vld_nxt = live | wr_sel;
      else if (is_check && cmd_clear)  vld_nxt = live & ~live_hit;
      else if (is_inv_reg)             vld_nxt = live & ~live_hit;
      else if (is_inv_all)             vld_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            ent_tag[i]  <= '0;
            ent_addr[i] <= '0;
            ent_size[i] <= '0;
         end
      end else begin
         ent_vld <= vld_nxt;
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_sel[i]) begin
               ent_tag[i]  <= tag_in;
               ent_addr[i] <= cmd_addr;
               ent_size[i] <= cmd_size;
            end
         end
      end
   end

   // registered check result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
      end else begin
         res_valid <= is_check;
         res_hit   <= is_check && (|live_hit);
      end
   end
endmodule

// File: rtl/sat_chk.sv
`timescale 1ns/1ps
module sat_chk
   import sat_pkg::*;
#(
   parameter int ENTRIES = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic [2:0]         cmd_op,
   input logic               cmd_clear,
   input logic               st_valid,
   input logic               res_valid,
   input logic               res_hit,
   input logic [ENTRIES-1:0] vld_vec
);
   // R11
   res_follows_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_CHECK) |=> res_valid);

   // R11
   no_spurious_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_op == OP_CHECK) |=> !res_valid);

   // R10
   inv_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_INV_ALL) |=> (vld_vec == '0));

   // R2
   alloc_occupies_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_ALLOC) |=> (vld_vec != '0));

   // R5
   store_never_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && !(cmd_valid && cmd_op == OP_ALLOC)) |=>
      ($countones(vld_vec) <= $past($countones(vld_vec))));

   // R4
   clear_hit_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_hit && $past(cmd_clear)) |-> ($countones(vld_vec) < $past($countones(vld_vec))));

   // R9
   inv_reg_never_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_INV_REG) |=>
      ($countones(vld_vec) <= $past($countones(vld_vec))));

   // R11
   hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid);
endmodule

bind spec_addr_table sat_chk #(.ENTRIES(ENTRIES)) u_sat_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_clear (cmd_clear),
   .st_valid  (st_valid),
   .res_valid (res_valid),
   .res_hit   (res_hit),
   .vld_vec   (ent_vld)
);

// File: tb/spec_addr_table_tb_top.sv
`timescale 1ns/1ps
module spec_addr_table_tb_top;
   import sat_pkg::*;

   localparam int ENTRIES   = 32;
   localparam int REG_IDX_W = 7;
   localparam int ADDR_W    = 48;
   localparam int SIZE_W    = 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cmd_valid = 1'b0;
   logic [2:0]           cmd_op = 3'd0;
   logic                 cmd_clear = 1'b0;
   logic [REG_IDX_W-1:0] cmd_reg = '0;
   logic                 cmd_fp = 1'b0;
   logic [ADDR_W-1:0]    cmd_addr = '0;
   logic [SIZE_W-1:0]    cmd_size = '0;
   logic                 st_valid = 1'b0;
   logic [ADDR_W-1:0]    st_addr = '0;
   logic [SIZE_W-1:0]    st_size = '0;
   logic                 res_valid, res_hit;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #2 clk = ~clk;   // 250 MHz

   spec_addr_table #(
      .ENTRIES(ENTRIES), .REG_IDX_W(REG_IDX_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_clear(cmd_clear), .cmd_reg(cmd_reg), .cmd_fp(cmd_fp),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size), .st_valid(st_valid),
      .st_addr(st_addr), .st_size(st_size), .res_valid(res_valid), .res_hit(res_hit)
   );

   task automatic expect_bit(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic go_idle();
      cmd_valid = 1'b0; cmd_op = OP_IDLE; cmd_clear = 1'b0; st_valid = 1'b0;
   endtask

   task automatic set_cmd(input logic [2:0] op, input int rg, input logic fp,
                          input logic [ADDR_W-1:0] a, input int sz, input logic clr);
      cmd_valid = 1'b1; cmd_op = op; cmd_reg = REG_IDX_W'(rg); cmd_fp = fp;
      cmd_addr = a; cmd_size = SIZE_W'(sz); cmd_clear = clr;
   endtask

   task automatic do_cmd(input logic [2:0] op, input int rg, input logic fp,
                         input logic [ADDR_W-1:0] a, input int sz);
      @(negedge clk);
      set_cmd(op, rg, fp, a, sz, 1'b0);
      @(negedge clk);
      go_idle();
   endtask

   task automatic do_alloc(input int rg, input logic fp, input logic [ADDR_W-1:0] a, input int sz);
      do_cmd(OP_ALLOC, rg, fp, a, sz);
   endtask

   task automatic do_store(input logic [ADDR_W-1:0] a, input int sz);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_size = SIZE_W'(sz);
      @(negedge clk);
      go_idle();
   endtask

   // check command; result sampled at the following negedge
   task automatic do_check(input string req, input int rg, input logic fp,
                           input logic clr, input logic exp_hit);
      @(negedge clk);
      set_cmd(OP_CHECK, rg, fp, '0, 0, clr);
      @(negedge clk);
      go_idle();
      expect_bit({req, " res_valid"}, res_valid, 1'b1);
      expect_bit({req, " res_hit"}, res_hit, exp_hit);
   endtask

   task automatic t_reset();
      expect_bit("R1 res_valid after reset", res_valid, 1'b0);
      do_check("R1 empty table", 5, 1'b0, 1'b0, 1'b0);
      do_check("R1 empty table fp", 5, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_basic();
      do_alloc(5, 1'b0, 48'h1000, 3);
      expect_bit("R11 no result after alloc", res_valid, 1'b0);
      do_check("R2 class bit distinguishes", 5, 1'b1, 1'b0, 1'b0);
      do_check("R2 alloc then check", 5, 1'b0, 1'b0, 1'b1);
      do_check("R3 no-clear keeps entry", 5, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      expect_bit("R11 idle gives no result", res_valid, 1'b0);
   endtask

   task automatic t_clear();
      do_check("R4 clear check hits", 5, 1'b0, 1'b1, 1'b1);
      do_check("R4 entry gone after clear", 5, 1'b0, 1'b0, 1'b0);
      do_check("R4 never allocated misses", 9, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_store();
      do_cmd(OP_INV_ALL, 0, 1'b0, '0, 0);
      do_alloc(1, 1'b0, 48'h100, 2);   // 0x100..0x103
      do_alloc(2, 1'b0, 48'h200, 0);   // 0x200
      do_alloc(3, 1'b0, 48'h300, 3);   // 0x300..0x307
      do_store(48'h104, 2);            // abuts above
      do_check("R5 store abutting above keeps", 1, 1'b0, 1'b0, 1'b1);
      do_store(48'h0FC, 2);            // 0xFC..0xFF abuts below
      do_check("R5 store abutting below keeps", 1, 1'b0, 1'b0, 1'b1);
      do_store(48'h0FC, 3);            // 0xFC..0x103 overlaps
      do_check("R5 overlapping store removes", 1, 1'b0, 1'b0, 1'b0);
      do_store(48'h1FE, 1);            // 0x1FE..0x1FF
      do_check("R5 two-byte store abutting keeps", 2, 1'b0, 1'b0, 1'b1);
      do_store(48'h1FF, 1);            // 0x1FF..0x200
      do_check("R5 one shared byte removes", 2, 1'b0, 1'b0, 1'b0);
      do_store(48'h307, 0);
      do_check("R5 last byte removes", 3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_same_cycle();
      do_alloc(4, 1'b0, 48'h400, 3);
      do_alloc(6, 1'b0, 48'h600, 3);
      @(negedge clk);
      set_cmd(OP_CHECK, 4, 1'b0, '0, 0, 1'b0);
      st_valid = 1'b1; st_addr = 48'h404; st_size = 0;
      @(negedge clk);
      go_idle();
      expect_bit("R6 store ordered before check", res_hit, 1'b0);
      @(negedge clk);
      set_cmd(OP_CHECK, 6, 1'b0, '0, 0, 1'b0);
      st_valid = 1'b1; st_addr = 48'h608; st_size = 3;
      @(negedge clk);
      go_idle();
      expect_bit("R6 disjoint store with check", res_hit, 1'b1);
   endtask

   task automatic t_realloc();
      do_alloc(7, 1'b0, 48'h500, 3);
      do_alloc(7, 1'b0, 48'h700, 3);
      do_store(48'h500, 3);
      do_check("R7 old range replaced", 7, 1'b0, 1'b0, 1'b1);
      do_check("R7 clear single entry", 7, 1'b0, 1'b1, 1'b1);
      do_check("R7 no second entry", 7, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_capacity();
      do_cmd(OP_INV_ALL, 0, 1'b0, '0, 0);
      for (int i = 0; i < ENTRIES; i++) do_alloc(i, 1'b0, ADDR_W'(i * 16), 0);
      do_check("R8 last slot filled", ENTRIES - 1, 1'b0, 1'b0, 1'b1);
      do_alloc(40, 1'b0, 48'h9000, 0);
      do_check("R8 first victim evicted", 0, 1'b0, 1'b0, 1'b0);
      do_check("R8 second still present", 1, 1'b0, 1'b0, 1'b1);
      do_check("R8 new entry present", 40, 1'b0, 1'b0, 1'b1);
      do_alloc(41, 1'b0, 48'h9100, 0);
      do_check("R8 pointer advanced", 1, 1'b0, 1'b0, 1'b0);
      do_check("R8 third still present", 2, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_inv_reg();
      do_cmd(OP_INV_ALL, 0, 1'b0, '0, 0);
      do_alloc(10, 1'b0, 48'hA00, 3);
      do_alloc(10, 1'b1, 48'hB00, 3);
      do_alloc(11, 1'b0, 48'hC00, 3);
      do_cmd(OP_INV_REG, 12, 1'b0, '0, 0);
      do_check("R9 nonmatching inv keeps r10", 10, 1'b0, 1'b0, 1'b1);
      do_check("R9 nonmatching inv keeps r11", 11, 1'b0, 1'b0, 1'b1);
      do_cmd(OP_INV_REG, 10, 1'b0, '0, 0);
      do_check("R9 matching entry removed", 10, 1'b0, 1'b0, 1'b0);
      do_check("R9 other class kept", 10, 1'b1, 1'b0, 1'b1);
      do_check("R9 other register kept", 11, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_inv_all();
      do_alloc(20, 1'b0, 48'hD00, 2);
      do_cmd(OP_INV_ALL, 0, 1'b0, '0, 0);
      do_check("R10 all cleared gr", 20, 1'b0, 1'b0, 1'b0);
      do_check("R10 all cleared fp", 10, 1'b1, 1'b0, 1'b0);
      do_check("R10 all cleared r11", 11, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_clear();
      t_store();
      t_same_cycle();
      t_realloc();
      t_capacity();
      t_inv_reg();
      t_inv_all();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end
endmodule